// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Triggers

This block is a memory-mapped general-purpose I/O peripheral for up to 32 pins. Software picks the direction of each pin, sets the level driven on output pins, and reads back the pin levels. Input levels pass through a two-flop synchroniser before any use. The pad drivers are controlled directly through a per-pin output-enable vector.

Each pin can raise an interrupt on a high level, a low level, a rising edge, a falling edge, or on both edges. Three per-pin configuration words pick the trigger: an edge/level select word, a polarity word, and a both-edges word. Detected events are latched per pin in a raw status word. That word is masked by an enable word to form the pending word, and the OR of all pending bits drives one interrupt output. Software reads the pending word and writes the same value to a write-one-to-clear address. A read-only version word with a value of 3 or more tells software that both-edge detection exists.

The host port is a single-cycle 32-bit register interface with word addresses. A write takes effect at the clock edge where `wr_en` is high. Read data is combinational from the current address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every pin is an input (`pad_oe` all 0), the output value word is 0, the enable word is 0, the edge/level select and polarity words are all ones, the both-edges word is 0, the raw status word is 0 and `irq` is 0.
- R2: Word address 1 holds the direction word: bit 1 makes the pin an input (`pad_oe` low) and bit 0 makes it an output (`pad_oe` high). Word address 0 written sets `pad_out`.
- R3: A read of word address 0 returns the written value for output pins and, for input pins, the pad level after two register stages. A pad change made before clock edge k is visible from edge k+1.
- R4: When a pin's edge/level select bit (word address 6) is 0, the pin is level triggered. Polarity bit (word address 7) 1 means active high and 0 means active low. The status bit sets on every cycle the synchronised level is active, so it comes back right after a clear while the level stays active.
- R5: When the edge/level select bit is 1 and the both-edges bit is 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge. The opposite edge latches nothing.
- R6: When both the both-edges bit (word address 9) and the edge/level select bit are 1, either transition latches the status bit, whatever the polarity bit holds.
- R7: Word address 8 reads the VERSION parameter (default 3). When VERSION is below 3, the both-edges word reads 0 and has no effect.
- R8: Writing word address 5 clears each status bit whose write-data bit is 1 and leaves the others unchanged. If an event arrives in the same cycle as the clear of that bit, the bit stays set.
- R9: Word address 3 reads the raw status whatever the enables are. Word address 4 reads status AND enable (enable at word address 2). `irq` is high when any pending bit is 1.
- R10: Writes to word addresses 3, 4 and 8 have no effect. Word address 5 reads 0, and word addresses 10 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Word address of the register access |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | NPINS | Raw pad input levels |
| pad_out | output | NPINS | Levels to drive on the pads |
| pad_oe | output | NPINS | Pad driver enable, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong synchroniser stage moves the input readback and every latched edge by one cycle. This shows on the value read and on `irq` within three clocks of a pad change. A wrong trigger decode or a lost clear leaves a status bit that differs from the reference on the very next read, and it shows on `irq` as soon as that pin is enabled. The bench compares `irq`, the pad controls and the read data for the address in use against a behavioural model on every clock. Directed steps walk each trigger mode, the clear-versus-event collision and the read-only addresses.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NPINS   = 32,
  parameter int VERSION = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       addr,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);

  localparam int  W        = NPINS;
  localparam bit  HAS_BOTH = (VERSION >= 3);
  localparam logic [3:0] A_VAL = 4'd0, A_DIR = 4'd1, A_EN = 4'd2, A_ST = 4'd3,
                         A_PEND = 4'd4, A_CLR = 4'd5, A_EDGE = 4'd6, A_POL = 4'd7,
                         A_VER = 4'd8, A_BOTH = 4'd9;

  logic [W-1:0] out_q, dir_q, en_q, st_q, edge_q, pol_q, both_q;
  logic [W-1:0] s1, s2, s3;
  logic [W-1:0] wd, clr, rise, fall, lvl_hit, edge_hit, ev;

  assign wd  = wdata[W-1:0];
  assign clr = (wr_en && addr == A_CLR) ? wd : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= '0;
    else        {s1, s2, s3} <= {pad_in, s1, s2};

  assign rise     = s2 & ~s3;
  assign fall     = ~s2 & s3;
  assign lvl_hit  = ~(s2 ^ pol_q);
  assign edge_hit = (both_q & (rise | fall)) | (~both_q & ((pol_q & rise) | (~pol_q & fall)));
  assign ev       = (edge_q & edge_hit) | (~edge_q & lvl_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      en_q   <= '0;
      edge_q <= '1;
      pol_q  <= '1;
      st_q   <= '0;
    end else begin
      st_q <= (st_q & ~clr) | ev;
      if (wr_en) begin
        case (addr)
          A_VAL:   out_q  <= wd;
          A_DIR:   dir_q  <= wd;
          A_EN:    en_q   <= wd;
          A_EDGE:  edge_q <= wd;
          A_POL:   pol_q  <= wd;
          default: ;
        endcase
      end
    end

  generate
    if (HAS_BOTH) begin : g_both
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                         both_q <= '0;
        else if (wr_en && addr == A_BOTH)   both_q <= wd;
    end else begin : g_noboth
      assign both_q = '0;
    end
  endgenerate

  assign pad_out = out_q;
  assign pad_oe  = ~dir_q;
  assign irq     = |(st_q & en_q);

  always_comb begin
    rdata = '0;
    case (addr)
      A_VAL:   rdata[W-1:0] = (dir_q & s2) | (~dir_q & out_q);
      A_DIR:   rdata[W-1:0] = dir_q;
      A_EN:    rdata[W-1:0] = en_q;
      A_ST:    rdata[W-1:0] = st_q;
      A_PEND:  rdata[W-1:0] = st_q & en_q;
      A_EDGE:  rdata[W-1:0] = edge_q;
      A_POL:   rdata[W-1:0] = pol_q;
      A_VER:   rdata        = 32'(VERSION);
      A_BOTH:  rdata[W-1:0] = both_q;
      default: rdata        = '0;
    endcase
  end

endmodule

module gpio_irq_ctrl_chk #(
  parameter int NPINS   = 32,
  parameter int VERSION = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       addr,
  input logic             wr_en,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic [NPINS-1:0] pad_oe,
  input logic             irq,
  input logic [NPINS-1:0] st_q,
  input logic [NPINS-1:0] en_q,
  input logic [NPINS-1:0] ev
);

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd1) |=> (pad_oe == ~$past(wdata[NPINS-1:0])));

  p_version_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd8) |-> (rdata == 32'(VERSION)));

  p_clear_without_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd5) |=> ((st_q & $past(wdata[NPINS-1:0]) & ~$past(ev)) == '0));

  p_event_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((st_q & $past(ev)) == $past(ev)));

  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq);

  p_clear_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd5) |-> (rdata == '0));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rdata(rdata), .pad_oe(pad_oe), .irq(irq), .st_q(st_q), .en_q(en_q), .ev(ev)
);

// File: tb/sim_gpio_irq_ctrl.sv
module sim_gpio_irq_ctrl;
  localparam int N = 32;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic [3:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;
  logic         irq;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NPINS(N), .VERSION(3)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // behavioural reference
  logic [31:0] m_out, m_dir, m_en, m_st, m_edge, m_pol, m_both;
  logic [31:0] h1, h2, h3;

  always @(posedge clk) begin : model
    logic [31:0] hit, wipe;
    bit up, dn;
    if (!rst_n) begin
      m_out = 0; m_dir = '1; m_en = 0; m_st = 0; m_edge = '1; m_pol = '1; m_both = 0;
      h1 = 0; h2 = 0; h3 = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        up = h2[i] && !h3[i];
        dn = !h2[i] && h3[i];
        if (!m_edge[i])     hit[i] = (h2[i] == m_pol[i]);
        else if (m_both[i]) hit[i] = up || dn;
        else                hit[i] = m_pol[i] ? up : dn;
      end
      wipe = (wr_en && addr == 4'd5) ? wdata : 32'd0;
      m_st = (m_st & ~wipe) | hit;
      h3 = h2; h2 = h1; h1 = pad_in;
      if (wr_en) begin
        if (addr == 4'd0) m_out  = wdata;
        if (addr == 4'd1) m_dir  = wdata;
        if (addr == 4'd2) m_en   = wdata;
        if (addr == 4'd6) m_edge = wdata;
        if (addr == 4'd7) m_pol  = wdata;
        if (addr == 4'd9) m_both = wdata;
      end
    end
  end

  function automatic logic [31:0] model_rd(input logic [3:0] a);
    case (a)
      4'd0: return (m_dir & h2) | (~m_dir & m_out);
      4'd1: return m_dir;
      4'd2: return m_en;
      4'd3: return m_st;
      4'd4: return m_st & m_en;
      4'd6: return m_edge;
      4'd7: return m_pol;
      4'd8: return 32'd3;
      4'd9: return m_both;
      default: return 32'd0;
    endcase
  endfunction

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R2 model pad_oe", pad_oe, ~m_dir);
      chk("R2 model pad_out", pad_out, m_out);
      chk("R9 model irq", {31'd0, irq}, {31'd0, |(m_st & m_en)});
      chk("R3 model rdata", rdata, model_rd(addr));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 pad_oe after reset", pad_oe, 32'h0);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rdchk(4'd3, 32'h0, "R1 status after reset");
    rdchk(4'd6, 32'hFFFFFFFF, "R1 edge select after reset");
    rdchk(4'd7, 32'hFFFFFFFF, "R1 polarity after reset");
    rdchk(4'd1, 32'hFFFFFFFF, "R1 direction after reset");
    rdchk(4'd9, 32'h0, "R1 both-edge after reset");
    rdchk(4'd8, 32'd3, "R7 version value");

    wr(4'd1, 32'hFFFF0000);
    wr(4'd0, 32'h0000A5A5);
    chk("R2 pad_oe low half driven", pad_oe, 32'h0000FFFF);
    chk("R2 pad_out value", pad_out, 32'h0000A5A5);

    pad_in = 32'h12340000;
    @(negedge clk);
    rdchk(4'd0, 32'h0000A5A5, "R3 one stage not yet visible");
    @(negedge clk);
    rdchk(4'd0, 32'h1234A5A5, "R3 input and output readback");
    @(negedge clk);
    rdchk(4'd3, 32'h12340000, "R5 rising edges latched");
    rdchk(4'd4, 32'h0, "R9 pending masked by enable");
    chk("R9 irq low when disabled", {31'd0, irq}, 32'd0);

    wr(4'd2, 32'h00040000);
    rdchk(4'd4, 32'h00040000, "R9 pending after enable");
    chk("R9 irq high", {31'd0, irq}, 32'd1);

    wr(4'd5, 32'h00040000);
    rdchk(4'd3, 32'h12300000, "R8 write one clears");
    chk("R8 irq drops after clear", {31'd0, irq}, 32'd0);
    wr(4'd5, 32'h0);
    rdchk(4'd3, 32'h12300000, "R8 zero write leaves status");

    wr(4'd3, 32'hFFFFFFFF);
    wr(4'd4, 32'hFFFFFFFF);
    wr(4'd8, 32'h0);
    rdchk(4'd3, 32'h12300000, "R10 status ignores writes");
    rdchk(4'd8, 32'd3, "R10 version ignores writes");
    rdchk(4'd5, 32'h0, "R10 clear address reads zero");
    rdchk(4'd15, 32'h0, "R10 unmapped address reads zero");
    wr(4'd5, 32'hFFFFFFFF);
    rdchk(4'd3, 32'h0, "R8 clear all");

    wr(4'd7, 32'hFFEFFFFF);
    pad_in = 32'h12240000;
    settle();
    rdchk(4'd3, 32'h00100000, "R5 falling edge with polarity 0");
    pad_in = 32'h12340000;
    settle();
    rdchk(4'd3, 32'h00100000, "R5 rising edge ignored with polarity 0");
    wr(4'd5, 32'hFFFFFFFF);
    rdchk(4'd3, 32'h0, "R5 cleared");

    wr(4'd9, 32'h01000000);
    rdchk(4'd9, 32'h01000000, "R6 both-edge readback");
    pad_in = 32'h13340000;
    settle();
    rdchk(4'd3, 32'h01000000, "R6 rising edge latched");
    wr(4'd5, 32'hFFFFFFFF);
    pad_in = 32'h12340000;
    settle();
    rdchk(4'd3, 32'h01000000, "R6 falling edge latched despite polarity 1");
    wr(4'd5, 32'hFFFFFFFF);
    rdchk(4'd3, 32'h0, "R6 cleared");

    wr(4'd2, 32'h0);
    wr(4'd6, 32'hEFFFFFFF);
    @(negedge clk);
    rdchk(4'd3, 32'h10000000, "R4 active high level latched");
    wr(4'd5, 32'h10000000);
    rdchk(4'd3, 32'h10000000, "R4 R8 level event beats clear");
    wr(4'd2, 32'h10000000);
    chk("R9 irq from level pin", {31'd0, irq}, 32'd1);
    pad_in = 32'h02340000;
    settle();
    wr(4'd5, 32'hFFFFFFFF);
    rdchk(4'd3, 32'h0, "R4 inactive level stays clear");
    wr(4'd7, 32'hEFEFFFFF);
    @(negedge clk);
    rdchk(4'd3, 32'h10000000, "R4 active low level latched");
    chk("R9 irq from active low pin", {31'd0, irq}, 32'd1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule